// File: doc/BRIEF.md
# Transmit Slew-Rate Calibrator

This block picks the 3-bit high-speed transmit slew-rate code of a USB 2.0 transmitter. A start pulse launches a fixed sequence. The block powers an on-chip ring oscillator, lets it settle, and turns on the counting clock. It then loads a window length and arms a frequency meter. The meter counts reference-clock cycles while the oscillator completes the window.

The block polls the meter at a fixed interval until the result is valid or a poll limit runs out. It then shuts the meter down, followed by the counting clock. A shared sequential divider turns the count into a code, and the block writes the code and finally switches the oscillator off.

The code is `round(floor(F * K * W / N) / 1000)`, clamped to 7, where:
- F is the reference frequency in MHz.
- K is the coefficient.
- W is the window length in oscillator cycles.
- N is the measured count.

A zero count gives code 3. A nonzero forced code bypasses the measurement altogether.

Top module: `slew_cal`

## Requirements
- R1: When `force_code` is nonzero at an accepted start, `code` takes that value and `done` pulses two clocks after the start was sampled. `ro_en` never rises and `fail` stays 0.
- R2: On a measured run, `ro_en` goes high one clock after the start is sampled. It stays high until the cycle in which `done` is high, and in that cycle it is already low.
- R3: Internally, the meter is armed only after the counting clock is on, the oscillator is enabled and the window target is loaded. The counting clock is switched off only after the meter is disarmed.
- R4: The measured count N is the number of reference cycles that elapse while the ring oscillator completes `WINDOW` (default 1024) cycles, plus a few cycles of synchronizer latency.
- R5: For a nonzero N the code is `floor((floor(ref_mhz*coef*WINDOW/N) + 500) / 1000)`.
- R6: A computed value above 7 is saturated to code 7.
- R7: A zero count produces code 3. When the oscillator does not run, the count reads zero.
- R8: The meter is polled every `POLL_CYC` clocks. If it is not valid by poll `POLL_LIMIT`, the run still completes using the count read, and `fail` is set to 1 until the next start; otherwise `fail` is 0.
- R9: `done` is high for exactly one clock per run.
- R10: A start while a run is in progress is ignored. A start in the same cycle as `done` is accepted and begins a new run.
- R11: After reset, `code`, `done`, `fail` and `ro_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; accepted only when idle |
| force_code | input | 3 | Forced slew-rate code; 0 selects measurement |
| ref_mhz | input | REF_W | Reference frequency in MHz |
| coef | input | COEF_W | Calibration coefficient |
| ro_clk | input | 1 | Ring-oscillator clock |
| ro_en | output | 1 | Ring-oscillator enable |
| code | output | 3 | Slew-rate code |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Meter timed out on the last run |

## Verification
Two events can fall in the same clock: the completion pulse of one run and the start of the next. The bench provokes this by raising `start` on the very negedge where it observes `done` high. It judges the result by checking that `ro_en` is high one clock later and that a second, correctly coded `done` follows. A start pulse injected in the middle of a measurement is the contrasting case. For that case the bench confirms that exactly one completion occurs and that the oscillator stays off afterwards.

// File: rtl/slew_cal_pkg.sv
package slew_cal_pkg;

    localparam int CODE_W        = 3;
    localparam int ROUND_HALF    = 500;
    localparam int SCALE_DIV     = 1000;
    localparam logic [CODE_W-1:0] FALLBACK_CODE = 3'd3;
    localparam logic [CODE_W-1:0] CODE_MAX      = 3'd7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_FRCK,
        ST_LOAD,
        ST_ARM,
        ST_POLL,
        ST_DISARM,
        ST_FRCK_OFF,
        ST_DIV1,
        ST_WAIT1,
        ST_DIV2,
        ST_WAIT2,
        ST_WRITE,
        ST_FINISH
    } cal_state_e;

    function automatic logic [CODE_W-1:0] clamp_code(input logic [31:0] v);
        return (v > 32'(CODE_MAX)) ? CODE_MAX : v[CODE_W-1:0];
    endfunction

endpackage

// File: rtl/slew_cal_div.sv
module slew_cal_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, acc_q, den_q, num_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, done_q;
    logic [W:0]    trial, diff;
    logic          fits;

    assign trial = {rem_q, acc_q[W-1]};
    assign diff  = trial - {1'b0, den_q};
    assign fits  = trial >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            acc_q  <= '0;
            den_q  <= '0;
            num_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q <= '0;
                acc_q <= num;
                den_q <= den;
                num_q <= num;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
                acc_q <= {acc_q[W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quot = acc_q;

    // R5: quotient is the floor of num/den
    p_quot_low_r5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (64'(acc_q) * 64'(den_q)) <= 64'(num_q));
    p_quot_high_r5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ((64'(acc_q) + 64'd1) * 64'(den_q)) > 64'(num_q));
    // R7: a zero count never reaches the divider
    p_den_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        start |-> den != '0);

endmodule

// File: rtl/slew_cal_meter.sv
module slew_cal_meter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ro_clk,
    input  logic             frck_en,
    input  logic             meter_en,
    input  logic [CNT_W-1:0] target,
    output logic             valid,
    output logic [CNT_W-1:0] count
);
    // Reference-domain copy of the arm signal, used only as the
    // asynchronous clear of the oscillator-domain logic.
    logic ro_arm_q;
    always_ff @(posedge clk) begin
        if (rst) ro_arm_q <= 1'b0;
        else     ro_arm_q <= meter_en;
    end

    logic [1:0]       en_sync;
    logic [CNT_W-1:0] ro_cnt;
    logic             ro_done;

    always_ff @(posedge ro_clk or negedge ro_arm_q) begin
        if (!ro_arm_q) begin
            en_sync <= '0;
            ro_cnt  <= '0;
            ro_done <= 1'b0;
        end else begin
            en_sync <= {en_sync[0], 1'b1};
            if (en_sync[1] && !ro_done) begin
                if (ro_cnt == target - 1'b1) ro_done <= 1'b1;
                ro_cnt <= ro_cnt + 1'b1;
            end
        end
    end

    logic [1:0]       done_sync;
    logic [CNT_W-1:0] ref_cnt;

    always_ff @(posedge clk) begin
        if (rst || !meter_en) begin
            done_sync <= '0;
            ref_cnt   <= '0;
        end else begin
            done_sync <= {done_sync[0], ro_done};
            if (frck_en && !done_sync[1] && (ref_cnt != '1))
                ref_cnt <= ref_cnt + 1'b1;
        end
    end

    assign valid = done_sync[1];
    assign count = done_sync[1] ? ref_cnt : '0;

    // R4: the count freezes once the window has ended
    p_count_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (meter_en && done_sync[1]) |=> (!meter_en || ref_cnt == $past(ref_cnt)));
    // R4: valid rises only while the meter is armed
    p_valid_armed_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> meter_en);

endmodule

// File: rtl/slew_cal.sv
module slew_cal
    import slew_cal_pkg::*;
#(
    parameter int REF_W      = 8,
    parameter int COEF_W     = 8,
    parameter int CNT_W      = 24,
    parameter int WINDOW     = 1024,
    parameter int SETTLE_CYC = 26,
    parameter int POLL_CYC   = 260,
    parameter int POLL_LIMIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        force_code,
    input  logic [REF_W-1:0]  ref_mhz,
    input  logic [COEF_W-1:0] coef,
    input  logic              ro_clk,
    output logic              ro_en,
    output logic [2:0]        code,
    output logic              done,
    output logic              fail
);
    localparam int PROD_W  = REF_W + COEF_W + $clog2(WINDOW) + 1;
    localparam int DIV_W   = (PROD_W > CNT_W) ? PROD_W : CNT_W;
    localparam int SET_W   = $clog2(SETTLE_CYC + 1);
    localparam int POLL_W  = $clog2(POLL_CYC + 1);
    localparam int NPOLL_W = $clog2(POLL_LIMIT + 1);

    cal_state_e         state;
    logic [SET_W-1:0]   set_cnt;
    logic [POLL_W-1:0]  poll_cnt;
    logic [NPOLL_W-1:0] npoll;
    logic               frck_en, meter_en;
    logic [CNT_W-1:0]   target_q, cnt_q;
    logic [DIV_W-1:0]   prod_q, q1_q;
    logic [CODE_W-1:0]  code_calc;

    logic               m_valid;
    logic [CNT_W-1:0]   m_count;

    slew_cal_meter #(.CNT_W(CNT_W)) u_meter (
        .clk      (clk),
        .rst      (rst),
        .ro_clk   (ro_clk),
        .frck_en  (frck_en),
        .meter_en (meter_en),
        .target   (target_q),
        .valid    (m_valid),
        .count    (m_count)
    );

    logic             div_start, div_done;
    logic [DIV_W-1:0] div_num, div_den, div_quot;

    assign div_start = (state == ST_DIV1) || (state == ST_DIV2);
    assign div_num   = (state == ST_DIV2) ? (q1_q + DIV_W'(ROUND_HALF)) : prod_q;
    assign div_den   = (state == ST_DIV2) ? DIV_W'(SCALE_DIV) : DIV_W'(cnt_q);

    slew_cal_div #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quot  (div_quot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            set_cnt   <= '0;
            poll_cnt  <= '0;
            npoll     <= '0;
            frck_en   <= 1'b0;
            meter_en  <= 1'b0;
            target_q  <= '0;
            cnt_q     <= '0;
            prod_q    <= '0;
            q1_q      <= '0;
            code_calc <= '0;
            ro_en     <= 1'b0;
            code      <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    fail   <= 1'b0;
                    prod_q <= DIV_W'(ref_mhz) * DIV_W'(coef) * DIV_W'(WINDOW);
                    if (force_code != '0) begin
                        code  <= force_code;
                        state <= ST_FINISH;
                    end else begin
                        ro_en   <= 1'b1;
                        set_cnt <= '0;
                        state   <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    set_cnt <= set_cnt + 1'b1;
                    if (set_cnt == SET_W'(SETTLE_CYC - 1)) state <= ST_FRCK;
                end
                ST_FRCK: begin
                    frck_en <= 1'b1;
                    state   <= ST_LOAD;
                end
                ST_LOAD: begin
                    target_q <= CNT_W'(WINDOW);
                    state    <= ST_ARM;
                end
                ST_ARM: begin
                    meter_en <= 1'b1;
                    poll_cnt <= '0;
                    npoll    <= '0;
                    state    <= ST_POLL;
                end
                ST_POLL: begin
                    poll_cnt <= poll_cnt + 1'b1;
                    if (poll_cnt == POLL_W'(POLL_CYC - 1)) begin
                        poll_cnt <= '0;
                        npoll    <= npoll + 1'b1;
                        if (m_valid || npoll == NPOLL_W'(POLL_LIMIT - 1)) begin
                            cnt_q <= m_count;
                            fail  <= !m_valid;
                            state <= ST_DISARM;
                        end
                    end
                end
                ST_DISARM: begin
                    meter_en <= 1'b0;
                    state    <= ST_FRCK_OFF;
                end
                ST_FRCK_OFF: begin
                    frck_en <= 1'b0;
                    if (cnt_q == '0) begin
                        code_calc <= FALLBACK_CODE;
                        state     <= ST_WRITE;
                    end else begin
                        state <= ST_DIV1;
                    end
                end
                ST_DIV1: state <= ST_WAIT1;
                ST_WAIT1: if (div_done) begin
                    q1_q  <= div_quot;
                    state <= ST_DIV2;
                end
                ST_DIV2: state <= ST_WAIT2;
                ST_WAIT2: if (div_done) begin
                    code_calc <= clamp_code(32'(div_quot));
                    state     <= ST_WRITE;
                end
                ST_WRITE: begin
                    code  <= code_calc;
                    state <= ST_FINISH;
                end
                ST_FINISH: begin
                    ro_en <= 1'b0;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a forced code never wakes the oscillator
    p_force_skip_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && force_code != '0) |=> (!ro_en && state == ST_FINISH));
    // R3: meter armed only with clock, oscillator and target in place
    p_arm_order_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(meter_en) |-> (frck_en && ro_en && target_q == CNT_W'(WINDOW)));
    // R3: counting clock drops only after the meter is disarmed
    p_frck_off_order_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(frck_en) |-> !meter_en);
    // R2: oscillator is off when completion is signalled
    p_ro_off_at_done_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !ro_en);
    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: the poll count never passes its limit
    p_poll_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POLL) |-> (npoll < NPOLL_W'(POLL_LIMIT)));

endmodule

// File: tb/tb_slew_cal.sv
`timescale 1ns/1ps
module tb_slew_cal;
    localparam real CLK_PERIOD = 40.0;
    localparam int  WIN        = 1024;
    localparam int  POLL_CYC   = 260;
    localparam int  POLL_LIMIT = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] force_code = '0;
    logic [7:0] ref_mhz = 8'd26;
    logic [7:0] coef = 8'd17;
    logic       ro_clk;
    logic       ro_en;
    logic [2:0] code;
    logic       done;
    logic       fail;

    int  total = 0;
    int  bad = 0;
    bit  ro_dead = 1'b0;
    real ro_half = CLK_PERIOD / 2.0;
    bit  finished = 1'b0;

    slew_cal dut (
        .clk(clk), .rst(rst), .start(start), .force_code(force_code),
        .ref_mhz(ref_mhz), .coef(coef), .ro_clk(ro_clk),
        .ro_en(ro_en), .code(code), .done(done), .fail(fail)
    );

    always #(CLK_PERIOD / 2.0) clk = ~clk;

    initial begin
        ro_clk = 1'b0;
        forever begin
            if (ro_en && !ro_dead) begin
                #(ro_half);
                ro_clk = ~ro_clk;
            end else begin
                ro_clk = 1'b0;
                @(ro_en or ro_dead);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int m, input int c);
        int q, r;
        if (c <= 0) return 3;
        q = (m * WIN) / c;
        r = (q + 500) / 1000;
        return (r > 7) ? 7 : r;
    endfunction

    // One run from the current negedge; returns at the negedge that sees done.
    task automatic do_run(input bit expect_ro, input bit poke, output int lat, output int ro_errs);
        lat = 0;
        ro_errs = 0;
        start = 1'b1;
        forever begin
            @(negedge clk);
            lat++;
            start = (poke && lat == 40) ? 1'b1 : 1'b0;
            if (done) begin
                if (ro_en) ro_errs++;
                break;
            end
            if (ro_en != expect_ro) ro_errs++;
            if (lat > 8000) break;
        end
        start = 1'b0;
    endtask

    task automatic measured(input real r, input int rm, input int cf, input string req);
        int lat, roe, lo, hi;
        ref_mhz = 8'(rm);
        coef = 8'(cf);
        force_code = '0;
        ro_half = CLK_PERIOD / 2.0 * r;
        lo = int'($floor(1024.0 * r)) - 1;
        hi = int'($ceil(1028.0 * r)) + 6;
        do_run(1'b1, 1'b0, lat, roe);
        // R5: code matches the formula for the count range implied by R4
        check(int'(code) <= exp_code(rm * cf, lo) && int'(code) >= exp_code(rm * cf, hi),
              req, int'(code), exp_code(rm * cf, (lo + hi) / 2));
        // R2: oscillator enabled throughout and off at done
        check(roe == 0, "R2", roe, 0);
        // R8: a valid measurement leaves fail low
        check(fail == 1'b0, "R8", int'(fail), 0);
        @(negedge clk);
        // R9: done lasts one cycle
        check(done == 1'b0, "R9", int'(done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat, roe;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        check(code == 3'd0, "R11", int'(code), 0);
        check(done == 1'b0, "R11", int'(done), 0);
        check(fail == 1'b0, "R11", int'(fail), 0);
        check(ro_en == 1'b0, "R11", int'(ro_en), 0);

        // R1: forced codes bypass measurement
        for (int i = 0; i < 4; i++) begin
            int fc;
            fc = 1 + int'($urandom % 7);
            force_code = 3'(fc);
            do_run(1'b0, 1'b0, lat, roe);
            check(int'(code) == fc, "R1", int'(code), fc);
            check(lat == 2, "R1", lat, 2);
            check(roe == 0, "R1", roe, 0);
            check(fail == 1'b0, "R1", int'(fail), 0);
            @(negedge clk);
        end

        // R5, R4: default parameters, directed ratios
        measured(0.25, 26, 17, "R5");
        measured(1.0, 26, 17, "R5");
        measured(0.125, 26, 17, "R4");

        // R5: random parameters and oscillator periods
        for (int i = 0; i < 18; i++) begin
            real r;
            r = 0.2 + 1.3 * real'($urandom % 1000) / 1000.0;
            measured(r, 20 + int'($urandom % 21), 10 + int'($urandom % 21), "R5");
        end

        // R6: saturation to 7
        measured(0.5, 200, 200, "R6");

        // R7, R8: dead oscillator -> zero count, fallback code, timeout
        ro_dead = 1'b1;
        force_code = '0;
        do_run(1'b1, 1'b0, lat, roe);
        check(code == 3'd3, "R7", int'(code), 3);
        check(fail == 1'b1, "R8", int'(fail), 1);
        check(lat >= POLL_CYC * POLL_LIMIT && lat <= POLL_CYC * POLL_LIMIT + 200,
              "R8", lat, POLL_CYC * POLL_LIMIT + 40);
        ro_dead = 1'b0;
        @(negedge clk);

        // R8: fail clears on the next start
        measured(0.5, 26, 17, "R8");

        // R10: start during a run is ignored
        ref_mhz = 8'd26; coef = 8'd17; ro_half = CLK_PERIOD / 2.0 * 0.3;
        do_run(1'b1, 1'b1, lat, roe);
        check(roe == 0, "R10", roe, 0);
        begin
            int extra;
            extra = 0;
            repeat (40) begin
                @(negedge clk);
                if (ro_en || done) extra++;
            end
            check(extra == 0, "R10", extra, 0);
        end

        // R10: start in the done cycle begins a new run
        do_run(1'b1, 1'b0, lat, roe);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ro_en == 1'b1, "R10", int'(ro_en), 1);
        begin
            int l2;
            l2 = 1;
            while (!done && l2 < 8000) begin
                @(negedge clk);
                l2++;
            end
            check(done == 1'b1, "R10", int'(done), 1);
            check(int'(code) == exp_code(26 * 17, 307) || int'(code) == exp_code(26 * 17, 320),
                  "R10", int'(code), exp_code(26 * 17, 312));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule